// File: doc/BRIEF.md
# Phase-Stepped 8-bit Accumulator Core

This block is a small 8-bit processor core with a 16-bit address space. It
drives every instruction through a fixed chain of one-tick phases: an opcode
read, a decode tick that advances the program counter, a wait tick and an
execute tick. Multi-byte instructions loop back through extra phases to read
operand bytes or to touch memory. Every access to the byte-wide synchronous
memory port has a phase of its own, so the number of cycles an instruction
takes can be worked out from its encoding alone.

The core holds eight byte registers (B, C, D, E, H, L, flags, A), a stack
pointer, a program counter and a 16-bit address index. It executes the no-op,
absolute and relative jumps (always or on a zero/carry condition), register
copies, immediate loads, and direct-address loads and stores of the
accumulator. Any other opcode acts as a no-op and pulses a stub indication.
A free-running tick counter lets an integrator measure instruction timing.

Top module: `cpu8_core`

## Requirements
- R1: While reset is low the core holds PC=0x0100, SP=0xFFFE and the register image B=0x00, C=0x13, D=0x00, E=0xD8, H=0x01, L=0x4D, flags=0xB0, A=0x01. On `regs_o` byte i (bits 8i+7..8i) holds register code i: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 flags, 7 A.
- R2: Each instruction starts with a tick that presents PC on `mem_addr`, with `mem_we` low. That tick is followed by decode, wait and execute ticks, so a single-byte instruction takes 4 ticks. The opcode is the byte read at PC.
- R3: Opcode 00ddd110 (ddd not 6) loads the following byte into register ddd. It takes 7 ticks and advances PC by 2.
- R4: Opcode 01dddsss (neither field 6) copies register sss into register ddd in 4 ticks.
- R5: An absolute jump (0xC3 always, or 110cc010) reads a low and then a high address byte. When its condition holds it loads PC={high,low} and takes 14 ticks; otherwise it takes 10 ticks and PC moves past the 3 bytes.
- R6: A relative jump (0x18 always, or 001cc000) reads one byte and, when the condition holds, adds it as a signed value to the PC that already points past that byte. A taken relative jump takes 11 ticks and one not taken takes 7.
- R7: The condition field cc is bits 4:3 of the opcode: 00 zero clear, 01 zero set, 10 carry clear, 11 carry set. Zero is flags bit 7 and carry is flags bit 4. A taken jump of either kind spends exactly 4 extra ticks.
- R8: Opcode 0xEA reads a low and a high address byte, then writes A to that address. `mem_we` is high for exactly one tick, the 12th tick of the instruction, and the instruction takes 14 ticks.
- R9: Opcode 0xFA reads a low and a high address byte and loads A from that address in 14 ticks.
- R10: Every other opcode takes 4 ticks, changes no register, and raises `stub_hit` for exactly one tick, the 4th tick of the instruction.
- R11: `cycle_count` is 0 in reset and rises by one on every clock edge after reset.
- R12: No instruction changes the flags register or SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data (always A) |
| mem_we | output | 1 | Write strobe for the addressed byte |
| mem_rdata | input | 8 | Read data, valid the tick after the address |
| regs_o | output | 64 | Byte register file, byte i = register code i |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |
| cycle_count | output | CYC_W | Ticks since reset release |
| stub_hit | output | 1 | One-tick pulse on an unimplemented opcode |

## Verification
On every cycle the assertions check that the tick counter steps by one, that the flags and SP never move, that a stub pulse and a write strobe each last a single tick, and that every write carries the accumulator. Instruction lengths, branch outcomes for each condition polarity, signed relative offsets, the tick on which a store lands and register contents after loads and copies all need a program to run. The bench shows them by checking the fetch address at each computed instruction boundary, the time and content of each write, and the register file at the end.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    typedef enum logic [3:0] {
        PH_FETCH,
        PH_DECODE,
        PH_STALL,
        PH_EXEC,
        PH_OPRD,
        PH_OPWAIT,
        PH_IDX_LD,
        PH_IDX_ST,
        PH_MEM_LD,
        PH_MEM_ST,
        PH_PENALTY
    } phase_e;

    typedef enum logic [2:0] {
        IC_NOP,
        IC_JP,
        IC_JR,
        IC_LDRR,
        IC_LDRN,
        IC_STA,
        IC_LDA,
        IC_STUB
    } iclass_e;

    localparam int unsigned RCODE_F = 6;
    localparam int unsigned RCODE_A = 7;
    localparam int unsigned FLAG_Z  = 7;
    localparam int unsigned FLAG_C  = 4;

    // byte order {A, F, L, H, E, D, C, B}
    function automatic logic [63:0] reset_image();
        return {8'h01, 8'hB0, 8'h4D, 8'h01, 8'hD8, 8'h00, 8'h13, 8'h00};
    endfunction

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [7:0] op,
    input  logic [7:0] flags,
    output iclass_e    cls,
    output logic [2:0] dst,
    output logic [2:0] src,
    output logic       cond_ok
);
    logic always_taken;

    assign dst = op[5:3];
    assign src = op[2:0];
    assign always_taken = (op == 8'hC3) || (op == 8'h18);

    always_comb begin
        if (always_taken) begin
            cond_ok = 1'b1;
        end else begin
            unique case (op[4:3])
                2'b00:   cond_ok = ~flags[FLAG_Z];
                2'b01:   cond_ok =  flags[FLAG_Z];
                2'b10:   cond_ok = ~flags[FLAG_C];
                default: cond_ok =  flags[FLAG_C];
            endcase
        end
    end

    always_comb begin
        cls = IC_STUB;
        if (op == 8'h00) begin
            cls = IC_NOP;
        end else if (op == 8'hC3 || (op[7:5] == 3'b110 && op[2:0] == 3'b010)) begin
            cls = IC_JP;
        end else if (op == 8'h18 || (op[7:5] == 3'b001 && op[2:0] == 3'b000)) begin
            cls = IC_JR;
        end else if (op == 8'hEA) begin
            cls = IC_STA;
        end else if (op == 8'hFA) begin
            cls = IC_LDA;
        end else if (op[7:6] == 2'b01 && op[5:3] != 3'd6 && op[2:0] != 3'd6) begin
            cls = IC_LDRR;
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'd6 && op[5:3] != 3'd6) begin
            cls = IC_LDRN;
        end
    end
endmodule

// File: rtl/cpu8_tick_counter.sv
module cpu8_tick_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb count_d = count_q + W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int unsigned CYC_W         = 32,
    parameter int unsigned TAKEN_PENALTY = 4,
    parameter logic [15:0] RESET_PC      = 16'h0100,
    parameter logic [15:0] RESET_SP      = 16'hFFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    input  logic [7:0]       mem_rdata,
    output logic [63:0]      regs_o,
    output logic [15:0]      sp_o,
    output logic [15:0]      pc_o,
    output logic [CYC_W-1:0] cycle_count,
    output logic             stub_hit
);
    // TAKEN_PENALTY must be at least 1
    localparam int unsigned PW = (TAKEN_PENALTY > 1) ? $clog2(TAKEN_PENALTY) : 1;
    localparam logic [PW-1:0] PEN_INIT = PW'(TAKEN_PENALTY - 1);

    typedef struct packed {
        phase_e          phase;
        logic [1:0]      step;
        logic [7:0]      op;
        logic [7:0]      bus;
        logic [15:0]     idx;
        logic [15:0]     pc;
        logic [15:0]     sp;
        logic [7:0][7:0] regs;
        logic [PW-1:0]   pen;
    } core_t;

    core_t   state_d, state_q;
    iclass_e cls;
    logic [2:0] dst, src;
    logic cond_ok;

    cpu8_decode u_decode (
        .op      (state_q.op),
        .flags   (state_q.regs[RCODE_F]),
        .cls     (cls),
        .dst     (dst),
        .src     (src),
        .cond_ok (cond_ok)
    );

    cpu8_tick_counter #(.W(CYC_W)) u_ticks (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_count)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q.phase)
            PH_FETCH:  state_d.phase = PH_DECODE;
            PH_DECODE: begin
                state_d.op    = mem_rdata;
                state_d.pc    = state_q.pc + 16'd1;
                state_d.step  = 2'd0;
                state_d.phase = PH_STALL;
            end
            PH_STALL: begin
                state_d.bus   = mem_rdata;
                state_d.phase = PH_EXEC;
            end
            PH_OPRD: begin
                state_d.pc    = state_q.pc + 16'd1;
                state_d.phase = PH_OPWAIT;
            end
            PH_OPWAIT: begin
                state_d.bus   = mem_rdata;
                state_d.phase = PH_EXEC;
            end
            PH_IDX_LD: state_d.phase = PH_MEM_LD;
            PH_IDX_ST: state_d.phase = PH_MEM_ST;
            PH_MEM_LD, PH_MEM_ST: state_d.phase = PH_STALL;
            PH_PENALTY: begin
                if (state_q.pen == '0) state_d.phase = PH_FETCH;
                else                   state_d.pen   = state_q.pen - PW'(1);
            end
            PH_EXEC: begin
                state_d.phase = PH_FETCH;
                unique case (cls)
                    IC_LDRR: state_d.regs[dst] = state_q.regs[src];
                    IC_LDRN: begin
                        if (state_q.step == 2'd0) begin
                            state_d.phase = PH_OPRD;
                            state_d.step  = 2'd1;
                        end else begin
                            state_d.regs[dst] = state_q.bus;
                        end
                    end
                    IC_JR: begin
                        if (state_q.step == 2'd0) begin
                            state_d.phase = PH_OPRD;
                            state_d.step  = 2'd1;
                        end else if (cond_ok) begin
                            state_d.pc    = state_q.pc + {{8{state_q.bus[7]}}, state_q.bus};
                            state_d.phase = PH_PENALTY;
                            state_d.pen   = PEN_INIT;
                        end
                    end
                    IC_JP: begin
                        unique case (state_q.step)
                            2'd0: begin
                                state_d.phase = PH_OPRD;
                                state_d.step  = 2'd1;
                            end
                            2'd1: begin
                                state_d.idx[7:0] = state_q.bus;
                                state_d.phase    = PH_OPRD;
                                state_d.step     = 2'd2;
                            end
                            default: begin
                                if (cond_ok) begin
                                    state_d.pc    = {state_q.bus, state_q.idx[7:0]};
                                    state_d.phase = PH_PENALTY;
                                    state_d.pen   = PEN_INIT;
                                end
                            end
                        endcase
                    end
                    IC_STA, IC_LDA: begin
                        unique case (state_q.step)
                            2'd0: begin
                                state_d.phase = PH_OPRD;
                                state_d.step  = 2'd1;
                            end
                            2'd1: begin
                                state_d.idx[7:0] = state_q.bus;
                                state_d.phase    = PH_OPRD;
                                state_d.step     = 2'd2;
                            end
                            2'd2: begin
                                state_d.idx[15:8] = state_q.bus;
                                state_d.phase     = (cls == IC_STA) ? PH_IDX_ST : PH_IDX_LD;
                                state_d.step      = 2'd3;
                            end
                            default: begin
                                if (cls == IC_LDA) state_d.regs[RCODE_A] = state_q.bus;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
            default: state_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.phase <= PH_FETCH;
            state_q.pc    <= RESET_PC;
            state_q.sp    <= RESET_SP;
            state_q.regs  <= reset_image();
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mem_addr = state_q.pc;
        if (state_q.phase == PH_MEM_LD || state_q.phase == PH_MEM_ST) mem_addr = state_q.idx;
    end

    assign mem_we    = (state_q.phase == PH_MEM_ST);
    assign mem_wdata = state_q.regs[RCODE_A];
    assign stub_hit  = (state_q.phase == PH_EXEC) && (cls == IC_STUB);
    assign regs_o    = state_q.regs;
    assign sp_o      = state_q.sp;
    assign pc_o      = state_q.pc;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk #(
    parameter int unsigned CYC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CYC_W-1:0] cycle_count,
    input logic             stub_hit,
    input logic             mem_we,
    input logic [7:0]       mem_wdata,
    input logic [63:0]      regs_o,
    input logic [15:0]      sp_o
);
    // R11
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_count == $past(cycle_count) + CYC_W'(1));

    // R10
    stub_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stub_hit |=> !stub_hit);

    // R8
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8
    write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata == regs_o[63:56]);

    // R12
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(regs_o[55:48]));

    // R12
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(sp_o));
endmodule

bind cpu8_core cpu8_core_chk #(.CYC_W(CYC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_count (cycle_count),
    .stub_hit    (stub_hit),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .regs_o      (regs_o),
    .sp_o        (sp_o)
);

// File: tb/cpu8_core_bench.sv
module cpu8_core_bench;
    localparam int CYC_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [63:0] regs_o;
    logic [15:0] sp_o, pc_o;
    logic [CYC_W-1:0] cycle_count;
    logic stub_hit;

    always #10 clk = ~clk;

    cpu8_core #(.CYC_W(CYC_W)) u_cpu8_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .regs_o(regs_o), .sp_o(sp_o),
        .pc_o(pc_o), .cycle_count(cycle_count), .stub_hit(stub_hit)
    );

    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:0]];
    end

    int vectors = 0;
    int fails   = 0;
    bit run     = 0;
    bit done    = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // instruction boundary table: tick, fetch address, requirement timed
    int          bt [0:31];
    logic [15:0] bp [0:31];
    string       br [0:31];
    int          nb = 0;
    task automatic boundary(input int t, input logic [15:0] p, input string r);
        bt[nb] = t; bp[nb] = p; br[nb] = r; nb++;
    endtask

    int          wt [0:3];
    logic [15:0] wa [0:3];
    logic [7:0]  wd [0:3];
    int          nw = 0;
    int          stubs = 0;

    task automatic put(input int a, input logic [7:0] b);
        mem[a] = b;
    endtask

    always @(negedge clk) begin
        if (run && !done) begin
            for (int i = 0; i < nb; i++) begin
                if (int'(cycle_count) == bt[i]) begin
                    check(br[i], $sformatf("fetch addr @%0d", bt[i]), 64'(mem_addr), 64'(bp[i]));
                    check(br[i], $sformatf("pc @%0d", bt[i]), 64'(pc_o), 64'(bp[i]));
                end
            end
            if (mem_we) begin
                if (nw < 3) begin
                    check("R8", "write tick", 64'(cycle_count), 64'(wt[nw]));
                    check("R8", "write addr", 64'(mem_addr), 64'(wa[nw]));
                    check("R8", "write data", 64'(mem_wdata), 64'(wd[nw]));
                end
                nw++;
            end
            if (stub_hit) begin
                check("R10", "stub tick", 64'(cycle_count), 64'd149);
                stubs++;
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 5000, 216);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        put(12'h100, 8'h3E); put(12'h101, 8'h5A);                       // A = 5A
        put(12'h102, 8'h06); put(12'h103, 8'h11);                       // B = 11
        put(12'h104, 8'h48);                                            // C = B
        put(12'h105, 8'h51);                                            // D = C
        put(12'h106, 8'h5F);                                            // E = A
        put(12'h107, 8'hEA); put(12'h108, 8'h00); put(12'h109, 8'h08);  // [0800] = A
        put(12'h10A, 8'hC2); put(12'h10B, 8'h00); put(12'h10C, 8'h02);  // abs, Z clear
        put(12'h10D, 8'hD2); put(12'h10E, 8'h00); put(12'h10F, 8'h02);  // abs, C clear
        put(12'h110, 8'h20); put(12'h111, 8'h05);                       // rel, Z clear
        put(12'h112, 8'h30); put(12'h113, 8'h05);                       // rel, C clear
        put(12'h114, 8'h28); put(12'h115, 8'h02);                       // rel +2, Z set
        put(12'h116, 8'h06); put(12'h117, 8'hFF);                       // skipped
        put(12'h118, 8'h38); put(12'h119, 8'h01);                       // rel +1, C set
        put(12'h11A, 8'hD3);                                            // skipped
        put(12'h11B, 8'hDA); put(12'h11C, 8'h30); put(12'h11D, 8'h01);  // abs 0130, C set
        put(12'h12B, 8'hCA); put(12'h12C, 8'h40); put(12'h12D, 8'h01);  // abs 0140, Z set
        put(12'h130, 8'h78);                                            // A = B
        put(12'h131, 8'hEA); put(12'h132, 8'h01); put(12'h133, 8'h08);  // [0801] = A
        put(12'h134, 8'hFA); put(12'h135, 8'h00); put(12'h136, 8'h08);  // A = [0800]
        put(12'h137, 8'h67);                                            // H = A
        put(12'h138, 8'hD3);                                            // unimplemented
        put(12'h139, 8'h18); put(12'h13A, 8'hF0);                       // rel -16
        put(12'h140, 8'hEA); put(12'h141, 8'h02); put(12'h142, 8'h08);  // [0802] = A
        put(12'h143, 8'hC3); put(12'h144, 8'h43); put(12'h145, 8'h01);  // self loop

        boundary(0,   16'h0100, "R2");
        boundary(7,   16'h0102, "R3");
        boundary(14,  16'h0104, "R3");
        boundary(18,  16'h0105, "R4");
        boundary(22,  16'h0106, "R4");
        boundary(26,  16'h0107, "R4");
        boundary(40,  16'h010A, "R8");
        boundary(50,  16'h010D, "R5");
        boundary(60,  16'h0110, "R5");
        boundary(67,  16'h0112, "R6");
        boundary(74,  16'h0114, "R6");
        boundary(85,  16'h0118, "R7");
        boundary(96,  16'h011B, "R7");
        boundary(110, 16'h0130, "R5");
        boundary(114, 16'h0131, "R4");
        boundary(128, 16'h0134, "R8");
        boundary(142, 16'h0137, "R9");
        boundary(146, 16'h0138, "R4");
        boundary(150, 16'h0139, "R10");
        boundary(161, 16'h012B, "R6");
        boundary(175, 16'h0140, "R5");
        boundary(189, 16'h0143, "R8");
        boundary(203, 16'h0143, "R5");

        wt[0] = 37;  wa[0] = 16'h0800; wd[0] = 8'h5A;
        wt[1] = 125; wa[1] = 16'h0801; wd[1] = 8'h11;
        wt[2] = 186; wa[2] = 16'h0802; wd[2] = 8'h5A;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset image
        check("R1", "regs in reset", regs_o, 64'h01B04D01D8001300);
        check("R1", "pc in reset", 64'(pc_o), 64'h0100);
        check("R1", "sp in reset", 64'(sp_o), 64'hFFFE);
        check("R11", "count in reset", 64'(cycle_count), 64'd0);
        check("R1", "we in reset", 64'(mem_we), 64'd0);

        @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1;
        repeat (216) @(posedge clk);
        @(negedge clk);
        check("R11", "tick count", 64'(cycle_count), 64'd216);
        check("R9",  "A after load", 64'(regs_o[63:56]), 64'h5A);
        check("R9",  "H copy of loaded A", 64'(regs_o[39:32]), 64'h5A);
        check("R3",  "B immediate, skipped reload", 64'(regs_o[7:0]), 64'h11);
        check("R4",  "C from B", 64'(regs_o[15:8]), 64'h11);
        check("R4",  "D from C", 64'(regs_o[23:16]), 64'h11);
        check("R4",  "E from A", 64'(regs_o[31:24]), 64'h5A);
        check("R10", "L untouched", 64'(regs_o[47:40]), 64'h4D);
        check("R12", "flags", 64'(regs_o[55:48]), 64'hB0);
        check("R12", "sp", 64'(sp_o), 64'hFFFE);
        check("R8",  "write count", 64'(nw), 64'd3);
        check("R10", "stub count", 64'(stubs), 64'd1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule